// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block drives an external analog multiplexer and a converter through a contiguous window of input channels. A host writes 16-bit words to four addresses. One address sets the window's first and last channel. One loads the gain and input-mode settings for the channel the multiplexer currently selects. One holds the trigger enables. A write to the fourth address fires a software conversion.

Three sources can start a conversion: a host strobe, a periodic pacer tick, and an external trigger pulse. Each source has its own enable. The pacer can also be qualified by an external gate level. The sequencer raises a one-cycle start pulse toward the converter and waits for the converter's done handshake. It then emits a 16-bit sample: the channel number sits in the top four bits above the 12-bit result. After that it steps to the next channel of the window, returning to the first channel after the last. A trigger that arrives during a conversion is dropped and sets a sticky overrun flag.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, adc_start, smp_valid and overrun are 0, adc_mux_chan is 0, every trigger source is disabled, and every channel's settings read as gain 0, bipolar, single-ended.
- R2: A write to address 2 takes the window's first channel from data bits 3:0 and its last channel from bits 11:8, and the scan pointer moves to the first channel. adc_mux_chan shows it one cycle later. Equal first and last values scan a single channel.
- R3: A write to address 1 stores the settings for the channel now on adc_mux_chan: bit 5 selects differential, bit 4 selects unipolar, and bits 2:0 are the gain code. adc_diff, adc_unipolar and adc_gain always present the stored settings of the selected channel.
- R4: Control register at address 3. Bit 0 enables the software strobe, bit 1 enables pacer_tick and bit 2 enables ext_trig. Bit 3, when set, lets a pacer tick count only while ext_gate is high. A source whose bit is clear starts nothing.
- R5: A write to address 0 starts one conversion on the current channel when bit 0 of the control register is set. The data written has no effect.
- R6: An accepted trigger gives a single-cycle adc_start on the next cycle. The sequencer stays busy until adc_done.
- R7: One cycle after adc_done ends a conversion, smp_valid pulses. smp_data bits 11:0 then hold adc_result and bits 15:12 hold the converted channel.
- R8: After each sample the pointer moves to the next channel. From the last channel it wraps to the first.
- R9: After the control register is written with 0, no source starts a conversion.
- R10: A trigger during a conversion starts nothing and sets overrun. Overrun stays set until the next control register write.
- R11: adc_done while no conversion is in progress produces no sample and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address (0 strobe, 1 settings, 2 window, 3 control) |
| wr_data | input | 16 | Host write data |
| pacer_tick | input | 1 | Pacer trigger pulse |
| ext_trig | input | 1 | External trigger pulse |
| ext_gate | input | 1 | External gate level for the pacer |
| adc_done | input | 1 | Converter done pulse |
| adc_result | input | 12 | Converter result, valid with adc_done |
| adc_start | output | 1 | Conversion start pulse |
| adc_mux_chan | output | 4 | Selected multiplexer channel |
| adc_gain | output | 3 | Gain code of the selected channel |
| adc_unipolar | output | 1 | Unipolar mode of the selected channel |
| adc_diff | output | 1 | Differential mode of the selected channel |
| smp_valid | output | 1 | Sample valid pulse |
| smp_data | output | 16 | Channel tag and result |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
The properties check on every cycle that:
- a window write lands on the multiplexer output and a settings write lands on the gain and mode outputs;
- start pulses are single and never follow a cleared control register;
- each sample carries the channel held at its start together with the converter's result;
- the pointer advances with wrap after each sample;
- overrun stays set until a control write;
- an idle done pulse yields nothing.

Only the scenarios show the rest. They cover per-channel settings surviving a full trip around the window, the gate qualifying the pacer, each enable bit blocking its own source, the exact count of starts when a trigger collides with a busy conversion, and the full sequence of sample tags and values.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ADDR_STRIKE = 2'd0,
        ADDR_RANGE  = 2'd1,
        ADDR_SPAN   = 2'd2,
        ADDR_CTRL   = 2'd3
    } reg_addr_e;

    // bit 3 .. bit 0 of the control word
    typedef struct packed {
        logic gate_en;
        logic ext_en;
        logic pacer_en;
        logic soft_en;
    } ctrl_t;

    // bit 5 diff, bit 4 unipolar, bits 2:0 gain
    typedef struct packed {
        logic       diff;
        logic       unipolar;
        logic [2:0] gain;
    } range_t;

    localparam int SPAN_FIELD_W = 8;
    localparam int RANGE_DIFF_BIT = 5;
    localparam int RANGE_UNI_BIT = 4;

endpackage

// File: rtl/adc_scan_trig.sv
module adc_scan_trig
    import adc_scan_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  soft_req,
    input  logic  pacer_tick,
    input  logic  ext_trig,
    input  logic  ext_gate,
    output logic  fire
);
    logic pacer_ok;
    logic soft_ok;
    logic ext_ok;

    always_comb begin
        pacer_ok = ctrl.pacer_en && pacer_tick && (!ctrl.gate_en || ext_gate);
        soft_ok  = ctrl.soft_en && soft_req;
        ext_ok   = ctrl.ext_en && ext_trig;
        fire     = pacer_ok || soft_ok || ext_ok;
    end
endmodule

// File: rtl/adc_scan_rangemem.sv
module adc_scan_rangemem
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CH_W-1:0] addr,
    input  range_t          wdata,
    output range_t          rdata
);
    localparam int DEPTH = 1 << CH_W;

    range_t mem_d [DEPTH];
    range_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/adc_scan_core.sv
module adc_scan_core
    import adc_scan_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int RES_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fire,
    input  logic              adc_done,
    input  logic [RES_W-1:0]  adc_result,
    output ctrl_t             ctrl,
    output logic [CH_W-1:0]   cur_chan,
    output logic [CH_W-1:0]   span_first,
    output logic [CH_W-1:0]   span_last,
    output logic              adc_start,
    output logic              smp_valid,
    output logic [CH_W+RES_W-1:0] smp_data,
    output logic              overrun
);
    localparam int SMP_W = CH_W + RES_W;

    typedef struct packed {
        logic [CH_W-1:0]  cur;
        logic [CH_W-1:0]  first;
        logic [CH_W-1:0]  last;
        logic [CH_W-1:0]  conv_chan;
        ctrl_t            ctrl;
        logic             busy;
        logic             start;
        logic             vld;
        logic             ovr;
        logic [SMP_W-1:0] smp;
    } state_t;

    state_t st_d, st_q;
    logic   span_wr;
    logic   ctrl_wr;
    logic   unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        span_wr = wr_en && (wr_addr == ADDR_SPAN);
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.vld   = 1'b0;

        if (ctrl_wr) begin
            st_d.ctrl = ctrl_t'(wr_data[3:0]);
            st_d.ovr  = 1'b0;
        end

        // conversion finished: emit tagged sample, step pointer
        if (st_q.busy && adc_done) begin
            st_d.busy = 1'b0;
            st_d.vld  = 1'b1;
            st_d.smp  = {st_q.conv_chan, adc_result};
            st_d.cur  = (st_q.cur == st_q.last) ? st_q.first : st_q.cur + 1'b1;
        end

        if (span_wr) begin
            st_d.first = wr_data[CH_W-1:0];
            st_d.last  = wr_data[SPAN_FIELD_W +: CH_W];
            st_d.cur   = wr_data[CH_W-1:0];
        end

        if (fire) begin
            if (!st_q.busy) begin
                st_d.busy      = 1'b1;
                st_d.start     = 1'b1;
                st_d.conv_chan = st_q.cur;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl       = st_q.ctrl;
    assign cur_chan   = st_q.cur;
    assign span_first = st_q.first;
    assign span_last  = st_q.last;
    assign adc_start  = st_q.start;
    assign smp_valid  = st_q.vld;
    assign smp_data   = st_q.smp;
    assign overrun    = st_q.ovr;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int RES_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  pacer_tick,
    input  logic                  ext_trig,
    input  logic                  ext_gate,
    input  logic                  adc_done,
    input  logic [RES_W-1:0]      adc_result,
    output logic                  adc_start,
    output logic [CH_W-1:0]       adc_mux_chan,
    output logic [2:0]            adc_gain,
    output logic                  adc_unipolar,
    output logic                  adc_diff,
    output logic                  smp_valid,
    output logic [CH_W+RES_W-1:0] smp_data,
    output logic                  overrun
);
    ctrl_t           ctrl_w;
    logic            soft_req;
    logic            range_we;
    logic            fire;
    logic [CH_W-1:0] cur_w;
    logic [CH_W-1:0] span_first_w;
    logic [CH_W-1:0] span_last_w;
    range_t          range_wr;
    range_t          range_rd;

    always_comb begin
        soft_req          = wr_en && (wr_addr == ADDR_STRIKE);
        range_we          = wr_en && (wr_addr == ADDR_RANGE);
        range_wr.diff     = wr_data[RANGE_DIFF_BIT];
        range_wr.unipolar = wr_data[RANGE_UNI_BIT];
        range_wr.gain     = wr_data[2:0];
    end

    adc_scan_trig u_trig (
        .ctrl       (ctrl_w),
        .soft_req   (soft_req),
        .pacer_tick (pacer_tick),
        .ext_trig   (ext_trig),
        .ext_gate   (ext_gate),
        .fire       (fire)
    );

    adc_scan_core #(.CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fire       (fire),
        .adc_done   (adc_done),
        .adc_result (adc_result),
        .ctrl       (ctrl_w),
        .cur_chan   (cur_w),
        .span_first (span_first_w),
        .span_last  (span_last_w),
        .adc_start  (adc_start),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .overrun    (overrun)
    );

    adc_scan_rangemem #(.CH_W(CH_W)) u_range (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (range_we),
        .addr  (cur_w),
        .wdata (range_wr),
        .rdata (range_rd)
    );

    assign adc_mux_chan = cur_w;
    assign adc_gain     = range_rd.gain;
    assign adc_unipolar = range_rd.unipolar;
    assign adc_diff     = range_rd.diff;
endmodule

// File: rtl/adc_scan_checks.sv
module adc_scan_checks #(
    parameter int CH_W   = 4,
    parameter int RES_W  = 12,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [1:0]            wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  adc_done,
    input logic [RES_W-1:0]      adc_result,
    input logic                  adc_start,
    input logic [CH_W-1:0]       adc_mux_chan,
    input logic [2:0]            adc_gain,
    input logic                  adc_unipolar,
    input logic                  adc_diff,
    input logic                  smp_valid,
    input logic [CH_W+RES_W-1:0] smp_data,
    input logic                  overrun,
    input logic [3:0]            ctrl_w,
    input logic [CH_W-1:0]       span_first_w,
    input logic [CH_W-1:0]       span_last_w
);
    localparam int SMP_W = CH_W + RES_W;

    logic [CH_W-1:0] tag_q;
    logic            pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (adc_start) begin
                tag_q  <= adc_mux_chan;
                pend_q <= 1'b1;
            end else if (adc_done) begin
                pend_q <= 1'b0;
            end
        end
    end

    p_span_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=> adc_mux_chan == $past(wr_data[CH_W-1:0]));

    p_range_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && !adc_done) |=>
        (adc_gain == $past(wr_data[2:0]) && adc_unipolar == $past(wr_data[4])
         && adc_diff == $past(wr_data[5])));

    p_single_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> smp_data[SMP_W-1:RES_W] == tag_q);

    p_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> smp_data[RES_W-1:0] == $past(adc_result));

    p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !$past(wr_en && wr_addr == 2'd2)) |->
        adc_mux_chan == (($past(adc_mux_chan) == span_last_w) ? span_first_w
                         : $past(adc_mux_chan) + 1'b1));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w == 4'd0) |=> !adc_start);

    p_overrun_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(wr_en && wr_addr == 2'd3)) |=> overrun);

    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_done && !pend_q && !adc_start) |=> !smp_valid);
endmodule

bind adc_scan_seq adc_scan_checks #(.CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .adc_done     (adc_done),
    .adc_result   (adc_result),
    .adc_start    (adc_start),
    .adc_mux_chan (adc_mux_chan),
    .adc_gain     (adc_gain),
    .adc_unipolar (adc_unipolar),
    .adc_diff     (adc_diff),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .overrun      (overrun),
    .ctrl_w       (ctrl_w),
    .span_first_w (span_first_w),
    .span_last_w  (span_last_w)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pacer_tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic        ext_gate = 1'b0;
    logic        stub_done = 1'b0;
    logic        poke_done = 1'b0;
    logic        adc_done;
    logic [11:0] adc_result = 12'd0;
    logic        adc_start;
    logic [3:0]  adc_mux_chan;
    logic [2:0]  adc_gain;
    logic        adc_unipolar;
    logic        adc_diff;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        overrun;

    int checks = 0;
    int fails = 0;
    int starts = 0;
    int samples = 0;
    int stub_n = 0;
    int exp_n = 0;
    logic [3:0] exp_first = 4'd0;
    logic [3:0] exp_last = 4'd0;
    logic [3:0] exp_ptr = 4'd0;
    logic [15:0] sb_q[$];

    always #10 clk = ~clk;

    assign adc_done = stub_done | poke_done;

    adc_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .ext_gate(ext_gate),
        .adc_done(adc_done), .adc_result(adc_result), .adc_start(adc_start),
        .adc_mux_chan(adc_mux_chan), .adc_gain(adc_gain), .adc_unipolar(adc_unipolar),
        .adc_diff(adc_diff), .smp_valid(smp_valid), .smp_data(smp_data), .overrun(overrun)
    );

    function automatic logic [11:0] res_of(input int n);
        return 12'(32'h3C1 + n * 215);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // converter stub: done two cycles after the start pulse is seen
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                repeat (2) @(negedge clk);
                stub_done  = 1'b1;
                adc_result = res_of(stub_n);
                stub_n++;
                @(negedge clk);
                stub_done = 1'b0;
            end
        end
    end

    // start counter and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && adc_start) starts++;
        if (rst_n && smp_valid) begin
            samples++;
            if (sb_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R7: actual %0h expected no sample", smp_data);
            end else begin
                chk("R7 sample tag/result", {16'd0, smp_data}, {16'd0, sb_q.pop_front()});
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'd0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_conv();
        sb_q.push_back({exp_ptr, res_of(exp_n)});
        exp_n++;
        exp_ptr = (exp_ptr == exp_last) ? exp_first : exp_ptr + 4'd1;
    endtask

    task automatic set_span(input logic [3:0] f, input logic [3:0] l);
        exp_first = f; exp_last = l; exp_ptr = f;
        reg_wr(2'd2, {4'hC, l, 4'hA, f});
    endtask

    task automatic soft_conv();
        expect_conv();
        reg_wr(2'd0, 16'hBEEF);
        settle();
    endtask

    task automatic pulse_pacer();
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        settle();
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 adc_start", {31'd0, adc_start}, 0);
        chk("R1 smp_valid", {31'd0, smp_valid}, 0);
        chk("R1 overrun", {31'd0, overrun}, 0);
        chk("R1 mux", {28'd0, adc_mux_chan}, 0);
        chk("R1 settings", {27'd0, adc_diff, adc_unipolar, adc_gain}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 all sources off: strobe starts nothing
        reg_wr(2'd0, 16'h0000);
        settle();
        chk("R1 no start with sources off", starts, 0);

        // R2 window load
        set_span(4'd2, 4'd5);
        chk("R2 mux at first", {28'd0, adc_mux_chan}, 2);

        // R3 settings for channel 2
        reg_wr(2'd1, 16'hFF23);
        chk("R3 ch2 settings", {27'd0, adc_diff, adc_unipolar, adc_gain}, {27'd0, 5'b10011});

        reg_wr(2'd3, 16'h0001);
        soft_conv();
        chk("R8 advance to 3", {28'd0, adc_mux_chan}, 3);
        chk("R5 one start per strobe", starts, 1);
        reg_wr(2'd1, 16'h0015);
        chk("R3 ch3 settings", {27'd0, adc_diff, adc_unipolar, adc_gain}, {27'd0, 5'b01101});
        soft_conv();
        soft_conv();
        soft_conv();
        chk("R8 wrap to first", {28'd0, adc_mux_chan}, 2);
        chk("R3 ch2 settings kept", {27'd0, adc_diff, adc_unipolar, adc_gain}, {27'd0, 5'b10011});

        // R2 single channel window
        set_span(4'd7, 4'd7);
        soft_conv();
        soft_conv();
        chk("R2 single channel stays", {28'd0, adc_mux_chan}, 7);

        // R4 pacer, gate, external
        reg_wr(2'd3, 16'h0002);
        expect_conv();
        pulse_pacer();
        chk("R4 pacer accepted", starts, 7);
        reg_wr(2'd0, 16'h0000);
        settle();
        chk("R4 strobe blocked when bit0 clear", starts, 7);
        reg_wr(2'd3, 16'h000A);
        ext_gate = 1'b0;
        pulse_pacer();
        chk("R4 pacer blocked by low gate", starts, 7);
        ext_gate = 1'b1;
        expect_conv();
        pulse_pacer();
        chk("R4 pacer passes high gate", starts, 8);
        pulse_ext();
        chk("R4 ext blocked when bit2 clear", starts, 8);
        reg_wr(2'd3, 16'h0004);
        expect_conv();
        pulse_ext();
        chk("R4 ext accepted", starts, 9);

        // R10 overrun on back-to-back strobes
        reg_wr(2'd3, 16'h0001);
        expect_conv();
        reg_wr(2'd0, 16'h1111);
        reg_wr(2'd0, 16'h2222);
        settle();
        chk("R10 busy trigger dropped", starts, 10);
        chk("R10 overrun set", {31'd0, overrun}, 1);
        soft_conv();
        chk("R10 overrun sticky", {31'd0, overrun}, 1);
        reg_wr(2'd3, 16'h0001);
        chk("R10 overrun cleared by control write", {31'd0, overrun}, 0);

        // R9 control zero
        reg_wr(2'd3, 16'h0000);
        reg_wr(2'd0, 16'h0000);
        settle();
        pulse_pacer();
        pulse_ext();
        chk("R9 no start after control zero", starts, 11);

        // R11 idle done
        begin
            int s0;
            s0 = samples;
            @(negedge clk); poke_done = 1'b1;
            @(negedge clk); poke_done = 1'b0;
            settle();
            chk("R11 no sample from idle done", samples, s0);
            chk("R11 pointer unmoved", {28'd0, adc_mux_chan}, {28'd0, exp_ptr});
        end

        chk("R7 scoreboard drained", sb_q.size(), 0);
        chk("R6 sample count", samples, 11);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule